// File: doc/BRIEF.md
# Colour Palette Lookup with Sequenced Component Loading

This block holds a 256-entry colour table, each entry a red, green and blue byte. Software loads it through a 16-byte register window of 32-bit words. One word selects the entry to load. The other word is written repeatedly: each write stores one colour byte, taken from the most significant byte of the data. A three-step sequencer decides which component the byte goes into.

A pixel pipeline reads the table through a separate lookup port and gets the packed colour one clock later. Each time an entry is modified, the block raises a one-cycle notification carrying that entry's number, so that display logic can mark the picture for refresh. Bus reads of the window return zero.

Top module: `palDac`

## Requirements
- R1: During and after reset, entries 0 to 254 hold 0x000000 and entry 255 holds 0xFFFFFF. Reset clears the entry pointer to 0 and the sequencer to red, so the first component write after reset lands in the red byte of entry 0.
- R2: A full-word write at byte offset 0x0 loads the entry pointer from data bits 31:24 and returns the sequencer to red, including when it is part-way through an entry.
- R3: Full-word writes at byte offset 0x4 store data bits 31:24 into the red, green and blue byte of the pointed entry, in that order. Each write advances the sequencer by one step, and data bits 23:0 and all other entries are left unchanged.
- R4: The blue write increments the entry pointer modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R5: A write is ignored when its byte offset is anything other than 0x0 or 0x4, or when its byte-enable is not 4'b1111. No entry changes, the pointer and sequencer hold, and no notification is raised.
- R6: The bus read data output is zero at all times.
- R7: The lookup output presents {red[23:16], green[15:8], blue[7:0]} of the entry addressed on the previous clock edge, one cycle of latency.
- R8: When a component write and a lookup address the same entry at the same clock edge, the lookup returns the value the entry held before the write.
- R9: In the cycle after each accepted component write, the notification output is high for exactly one cycle, and the changed-index output holds the entry written. In all other cycles the notification is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Byte offset within the register window |
| busByteEn | input | 4 | Byte enables; only 4'b1111 is a valid access |
| busWdata | input | 32 | Write data; component or index in bits 31:24 |
| busRdata | output | 32 | Register read data, always zero |
| lkAddr | input | 8 | Lookup entry number |
| lkRgb | output | 24 | Looked-up colour {R,G,B}, one cycle after lkAddr |
| entryChanged | output | 1 | One-cycle pulse after an entry is modified |
| changedIdx | output | 8 | Number of the modified entry, valid with entryChanged |

## Verification
The lookup port and the loading port work on the same table, so a component write and a lookup of the same entry can land on the same clock edge. The bench provokes this by driving the lookup address equal to the entry pointer while issuing a component write. It expects the pre-write colour on that cycle and the updated colour on the following lookup. A behavioural model of the table, the pointer and the sequencer predicts every output on every clock, so collisions that occur incidentally during the other scenarios are judged in the same way.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Table geometry
  parameter int PAL_IDX_W  = 8;
  parameter int PAL_COMP_W = 8;
  parameter int PAL_DEPTH  = 1 << PAL_IDX_W;
  parameter int PAL_RGB_W  = 3 * PAL_COMP_W;

  // Bus geometry
  parameter int BUS_DATA_W = 32;
  parameter int BUS_ADDR_W = 4;
  parameter int BUS_BE_W   = BUS_DATA_W / 8;

  // Register byte offsets (software visible)
  parameter logic [BUS_ADDR_W-1:0] OFF_INDEX = 4'h0;
  parameter logic [BUS_ADDR_W-1:0] OFF_COMP  = 4'h4;

  // Component sequencer state; the encoding doubles as the plane number
  typedef enum logic [1:0] {
    SEL_RED = 2'd0,
    SEL_GRN = 2'd1,
    SEL_BLU = 2'd2
  } compSel_e;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic                  wrEn;
    compSel_e              comp;
    logic [PAL_IDX_W-1:0]  idx;
    logic [PAL_COMP_W-1:0] val;
  } palStrb_t;
endpackage

// File: rtl/palCtrl.sv
module palCtrl
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int COMP_W = PAL_COMP_W,
  parameter int DATA_W = BUS_DATA_W,
  parameter int ADDR_W = BUS_ADDR_W,
  parameter int BE_W   = BUS_BE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output palStrb_t          strb
);
  localparam int TOP_LSB = DATA_W - COMP_W;

  logic              fullWord;
  logic              idxHit;
  logic              compHit;
  logic [COMP_W-1:0] topByte;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W-1:0]  idxNext;
  compSel_e          seqQ;
  compSel_e          seqNext;
  logic              unusedLowBits;

  assign fullWord = &busByteEn;
  assign idxHit   = busWrEn && fullWord && (busAddr == OFF_INDEX);
  assign compHit  = busWrEn && fullWord && (busAddr == OFF_COMP);
  assign topByte  = busWdata[DATA_W-1:TOP_LSB];

  // Low data bits carry nothing for this block
  assign unusedLowBits = ^busWdata[TOP_LSB-1:0];

  always_comb begin
    idxNext = idxQ;
    seqNext = seqQ;
    if (idxHit) begin
      idxNext = IDX_W'(topByte);
      seqNext = SEL_RED;
    end else if (compHit) begin
      unique case (seqQ)
        SEL_RED: seqNext = SEL_GRN;
        SEL_GRN: seqNext = SEL_BLU;
        default: begin
          seqNext = SEL_RED;
          idxNext = idxQ + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      seqQ <= SEL_RED;
    end else begin
      idxQ <= idxNext;
      seqQ <= seqNext;
    end
  end

  always_comb begin
    strb.wrEn = compHit;
    strb.comp = seqQ;
    strb.idx  = idxQ;
    strb.val  = topByte;
  end
endmodule

// File: rtl/palStore.sv
module palStore
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int COMP_W = PAL_COMP_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  palStrb_t            strb,
  input  logic [IDX_W-1:0]    lkAddr,
  output logic [3*COMP_W-1:0] lkRgb,
  output logic                entryChanged,
  output logic [IDX_W-1:0]    changedIdx
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int PLANES = 3;

  logic [COMP_W-1:0] rdByte [PLANES];

  // One storage plane per colour component; plane 0 is red
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [COMP_W-1:0] mem [DEPTH];
    logic              hitPlane;

    assign hitPlane = strb.wrEn && (strb.comp == compSel_e'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < DEPTH; e++) begin
          mem[e] <= (e == DEPTH - 1) ? '1 : '0;
        end
        rdByte[p] <= '0;
      end else begin
        rdByte[p] <= mem[lkAddr];
        if (hitPlane) begin
          mem[strb.idx] <= strb.val;
        end
      end
    end
  end

  assign lkRgb = {rdByte[0], rdByte[1], rdByte[2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryChanged <= 1'b0;
      changedIdx   <= '0;
    end else begin
      entryChanged <= strb.wrEn;
      if (strb.wrEn) begin
        changedIdx <= strb.idx;
      end
    end
  end
endmodule

// File: rtl/palDac.sv
module palDac
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int COMP_W = PAL_COMP_W,
  parameter int DATA_W = BUS_DATA_W,
  parameter int ADDR_W = BUS_ADDR_W,
  parameter int BE_W   = BUS_BE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BE_W-1:0]     busByteEn,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [IDX_W-1:0]    lkAddr,
  output logic [3*COMP_W-1:0] lkRgb,
  output logic                entryChanged,
  output logic [IDX_W-1:0]    changedIdx
);
  palStrb_t strb;

  // Register reads carry no information
  assign busRdata = '0;

  palCtrl #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .BE_W  (BE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busByteEn(busByteEn),
    .busWdata (busWdata),
    .strb     (strb)
  );

  palStore #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W)
  ) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lkAddr      (lkAddr),
    .lkRgb       (lkRgb),
    .entryChanged(entryChanged),
    .changedIdx  (changedIdx)
  );
endmodule

// File: rtl/palDacChk.sv
module palDacChk
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int DATA_W = BUS_DATA_W,
  parameter int ADDR_W = BUS_ADDR_W,
  parameter int BE_W   = BUS_BE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BE_W-1:0]   busByteEn,
  input logic [DATA_W-1:0] busWdata,
  input logic              entryChanged,
  input logic [IDX_W-1:0]  changedIdx
);
  logic compWr;
  logic idxWr;

  assign compWr = busWrEn && (&busByteEn) && (busAddr == OFF_COMP);
  assign idxWr  = busWrEn && (&busByteEn) && (busAddr == OFF_INDEX);

  // R9: an accepted component write is announced on the next cycle
  p_pulse_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    compWr |=> entryChanged);

  // R5: anything other than a component write raises no notification
  p_no_pulse_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    !compWr |=> !entryChanged);

  // R2: the first component after a pointer load targets the loaded entry
  p_index_load_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    idxWr ##1 compWr |=> (changedIdx == $past(busWdata[DATA_W-1 -: IDX_W], 2)));

  // R4: back-to-back component writes stay on one entry or move up by one
  p_index_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    compWr && $past(compWr) |=>
      ((changedIdx == $past(changedIdx)) || (changedIdx == IDX_W'($past(changedIdx) + 1'b1))));
endmodule

bind palDac palDacChk #(
  .IDX_W (IDX_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .BE_W  (BE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .busAddr     (busAddr),
  .busByteEn   (busByteEn),
  .busWdata    (busWdata),
  .entryChanged(entryChanged),
  .changedIdx  (changedIdx)
);

// File: tb/palDac_bench.sv
module palDac_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  lkAddr = '0;
  logic [23:0] lkRgb;
  logic        entryChanged;
  logic [7:0]  changedIdx;

  int testsRun = 0;
  int testsFailed = 0;

  // Behavioural reference
  int refR [256];
  int refG [256];
  int refB [256];
  int refIdx;
  int refSeq;
  logic [23:0] expLk;
  logic        expChg;
  logic [7:0]  expCidx;

  always #2 clk = ~clk;  // 250 MHz

  palDac u_palDac (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .lkAddr(lkAddr), .lkRgb(lkRgb), .entryChanged(entryChanged),
    .changedIdx(changedIdx)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int e = 0; e < 256; e++) begin
      refR[e] = (e == 255) ? 255 : 0;
      refG[e] = refR[e];
      refB[e] = refR[e];
    end
    refIdx = 0;
    refSeq = 0;
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit we, input logic [3:0] a, input logic [3:0] be,
                      input logic [7:0] d, input logic [7:0] la, input string tag);
    busWrEn   = we;
    busAddr   = a;
    busByteEn = be;
    busWdata  = {d, 24'hC3A55A};
    lkAddr    = la;
    @(posedge clk);
    expLk  = {refR[la][7:0], refG[la][7:0], refB[la][7:0]};
    expChg = 1'b0;
    if (we && be == 4'hF && a == 4'h0) begin
      refIdx = int'(d);
      refSeq = 0;
    end else if (we && be == 4'hF && a == 4'h4) begin
      expChg  = 1'b1;
      expCidx = refIdx[7:0];
      case (refSeq)
        0: refR[refIdx] = int'(d);
        1: refG[refIdx] = int'(d);
        default: refB[refIdx] = int'(d);
      endcase
      if (refSeq == 2) begin
        refSeq = 0;
        refIdx = (refIdx + 1) % 256;
      end else begin
        refSeq = refSeq + 1;
      end
    end
    @(negedge clk);
    check(lkRgb === expLk, {"R7 lookup ", tag}, 32'(lkRgb), 32'(expLk));
    check(entryChanged === expChg, {"R9 pulse ", tag}, 32'(entryChanged), 32'(expChg));
    if (expChg) check(changedIdx === expCidx, {"R9 index ", tag}, 32'(changedIdx), 32'(expCidx));
    check(busRdata === 32'h0, {"R6 read ", tag}, busRdata, 32'h0);
  endtask

  task automatic idle(input logic [7:0] la, input string tag);
    step(1'b0, 4'h0, 4'hF, 8'h00, la, tag);
  endtask

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected=%0d", testsRun, -1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    check(entryChanged === 1'b0, "R1 pulse in reset", 32'(entryChanged), 0);
    check(lkRgb === 24'h0, "R1 lookup in reset", 32'(lkRgb), 0);
    check(busRdata === 32'h0, "R6 read in reset", busRdata, 0);
    rstN = 1'b1;

    // R1: reset contents, swept through the lookup port
    for (int e = 0; e < 256; e++) idle(8'(e), "R1 reset contents");
    idle(8'd0, "R1 reset contents");

    // R1: first component after reset lands in red of entry 0
    step(1'b1, 4'h4, 4'hF, 8'h11, 8'd0, "R1 first write");
    idle(8'd0, "R1 entry0 red");
    idle(8'd0, "R1 entry0 red");

    // R2, R3: load pointer 5 and a full colour
    step(1'b1, 4'h0, 4'hF, 8'd5, 8'd5, "R2 index load");
    step(1'b1, 4'h4, 4'hF, 8'h12, 8'd5, "R3 red");
    step(1'b1, 4'h4, 4'hF, 8'h34, 8'd5, "R3 green");
    step(1'b1, 4'h4, 4'hF, 8'h56, 8'd5, "R3 blue");
    idle(8'd5, "R3 entry5");
    idle(8'd4, "R3 neighbour below");
    idle(8'd6, "R3 neighbour above");
    // R4: pointer moved to 6
    step(1'b1, 4'h4, 4'hF, 8'h78, 8'd6, "R4 auto increment");
    idle(8'd6, "R4 entry6");
    idle(8'd6, "R4 entry6");

    // R2: pointer reload mid-sequence restarts at red
    step(1'b1, 4'h0, 4'hF, 8'd9, 8'd9, "R2 load 9");
    step(1'b1, 4'h4, 4'hF, 8'hA1, 8'd9, "R2 red 9");
    step(1'b1, 4'h4, 4'hF, 8'hA2, 8'd9, "R2 green 9");
    step(1'b1, 4'h0, 4'hF, 8'd9, 8'd9, "R2 reload 9");
    step(1'b1, 4'h4, 4'hF, 8'hB1, 8'd9, "R2 red again");
    idle(8'd9, "R2 entry9");
    idle(8'd9, "R2 entry9");

    // R4: wrap from 255 to 0
    step(1'b1, 4'h0, 4'hF, 8'd255, 8'd255, "R4 load 255");
    step(1'b1, 4'h4, 4'hF, 8'h01, 8'd255, "R4 red 255");
    step(1'b1, 4'h4, 4'hF, 8'h02, 8'd255, "R4 green 255");
    step(1'b1, 4'h4, 4'hF, 8'h03, 8'd255, "R4 blue 255");
    step(1'b1, 4'h4, 4'hF, 8'h44, 8'd255, "R4 wrap red 0");
    idle(8'd0, "R4 entry0 after wrap");
    idle(8'd255, "R4 entry255");
    idle(8'd0, "R4 entry0");

    // R5: ignored accesses (pointer is 0, sequencer at green)
    step(1'b1, 4'h8, 4'hF, 8'hEE, 8'd0, "R5 offset 8");
    step(1'b1, 4'hC, 4'hF, 8'hEE, 8'd0, "R5 offset C");
    step(1'b1, 4'h5, 4'hF, 8'hEE, 8'd0, "R5 offset 5");
    step(1'b1, 4'h4, 4'h7, 8'hEE, 8'd0, "R5 partial comp");
    step(1'b1, 4'h0, 4'hE, 8'd77, 8'd0, "R5 partial index");
    idle(8'd0, "R5 entry0 unchanged");
    // next component still green of entry 0
    step(1'b1, 4'h4, 4'hF, 8'h55, 8'd0, "R5 state held");
    idle(8'd0, "R5 entry0 green");
    idle(8'd77, "R5 entry77 untouched");

    // R8: write and lookup of the same entry at one edge
    step(1'b1, 4'h0, 4'hF, 8'd20, 8'd20, "R8 load 20");
    step(1'b1, 4'h4, 4'hF, 8'h9C, 8'd20, "R8 collide red");
    idle(8'd20, "R8 after red");
    step(1'b1, 4'h4, 4'hF, 8'h8D, 8'd20, "R8 collide green");
    step(1'b1, 4'h4, 4'hF, 8'h7E, 8'd20, "R8 collide blue");
    idle(8'd20, "R8 after blue");
    idle(8'd21, "R8 neighbour");

    // Mixed pattern across many entries
    step(1'b1, 4'h0, 4'hF, 8'd100, 8'd0, "R3 burst load");
    for (int k = 0; k < 30; k++)
      step(1'b1, 4'h4, 4'hF, 8'(k * 37 + 3), 8'(100 + k / 3), "R3 burst");
    for (int e = 98; e < 112; e++) idle(8'(e), "R3 burst readback");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule